// File: doc/BRIEF.md
# Address Producer Learning Table

This block sits at decode and learns, for every logical integer register, which instruction last wrote it and which base-plus-offset loads later used that register as their base. Each register owns one entry. The entry holds the writer's PC, a learning/stable status, and a small list of consumer slots. Each slot records a load's destination register and its short offset.

On the producer port, a register-writing instruction compares its PC with the entry for its destination. When the PCs match, the stored knowledge is returned. When they differ, the old entry is handed out for a PC-indexed backing store, and a fresh learning entry takes its place. A backing store can also supply a whole entry alongside the producer, and that entry replaces the current one. On the consumer port, a load records itself in the entry of its base register. When the same (destination, offset) pair is seen a second time, the entry is promoted to stable. The producer response carries the stable flag and the valid slots, so that early loads can be launched.

Top module: `addr_producer_table`

## Requirements
- R1: After reset no register has an entry. The first producer to a register reports no eviction, and its response shows learning (stable=0) with no valid slots.
- R2: A producer whose PC differs from the PC of an occupied entry raises evict_valid one cycle later, carrying the old PC, status and slots. The new entry is learning with no valid slots.
- R3: A producer whose PC matches the stored PC leaves the entry unchanged and reports no eviction. Its response shows the stored status and slots.
- R4: A load whose (destination, offset) pair matches no valid slot fills the lowest-numbered free slot, with destination in bits [i*5 +: 5] of the dst vector and offset in bits [i*5 +: 5] of the offset vector. The status is not changed.
- R5: A load whose (destination, offset) pair equals a valid slot sets the entry's status to stable.
- R6: A load that finds every slot valid and none matching leaves the entry unchanged.
- R7: A load whose base register has had no producer since reset is ignored. A later first producer to that register still sees an empty, learning entry.
- R8: A producer that arrives with fill_valid writes the supplied status and slots whole. Eviction of a different old PC is still reported.
- R9: When the producer and the consumer target the same register in one cycle, the producer update is applied first, and the load is recorded in the newly allocated entry.
- R10: resp_valid rises exactly one cycle after prod_valid. The response shows the entry after the producer update and before any consumer update made in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prod_valid | input | 1 | Producer lookup this cycle |
| prod_reg | input | 5 | Producer destination register |
| prod_pc | input | 32 | Producer PC |
| fill_valid | input | 1 | Entry from backing store accompanies the producer |
| fill_stable | input | 1 | Supplied status (1 = stable) |
| fill_sub_valid | input | 2 | Supplied slot valid bits |
| fill_sub_dst | input | 10 | Supplied slot destinations, 5 bits per slot |
| fill_sub_off | input | 10 | Supplied slot offsets, 5 bits per slot |
| cons_valid | input | 1 | Consumer load this cycle |
| cons_base | input | 5 | Load base register |
| cons_dst | input | 5 | Load destination register |
| cons_off | input | 5 | Load offset |
| resp_valid | output | 1 | Producer response valid |
| resp_stable | output | 1 | Entry is stable |
| resp_sub_valid | output | 2 | Valid slots |
| resp_sub_dst | output | 10 | Slot destinations |
| resp_sub_off | output | 10 | Slot offsets |
| evict_valid | output | 1 | Old entry pushed out |
| evict_pc | output | 32 | Evicted PC |
| evict_stable | output | 1 | Evicted status |
| evict_sub_valid | output | 2 | Evicted slot valid bits |
| evict_sub_dst | output | 10 | Evicted slot destinations |
| evict_sub_off | output | 10 | Evicted slot offsets |

## Verification
A producer allocation and a consumer record can land on the same register in one cycle. The bench provokes this by issuing a mismatching producer and a load on the same register together. It first judges the immediate response, which must show an empty learning entry with the old entry evicted. A repeated producer with the same PC must then show the load in slot 0, which proves that the consumer update landed in the new entry and was not lost to the overwrite.

// File: rtl/addr_producer_table.sv
module addr_producer_table #(
  parameter int NREG  = 32,
  parameter int PC_W  = 32,
  parameter int OFF_W = 5,
  parameter int NSUB  = 2,
  parameter int RW    = $clog2(NREG)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  prod_valid,
  input  logic [RW-1:0]         prod_reg,
  input  logic [PC_W-1:0]       prod_pc,
  input  logic                  fill_valid,
  input  logic                  fill_stable,
  input  logic [NSUB-1:0]       fill_sub_valid,
  input  logic [NSUB*RW-1:0]    fill_sub_dst,
  input  logic [NSUB*OFF_W-1:0] fill_sub_off,
  input  logic                  cons_valid,
  input  logic [RW-1:0]         cons_base,
  input  logic [RW-1:0]         cons_dst,
  input  logic [OFF_W-1:0]      cons_off,
  output logic                  resp_valid,
  output logic                  resp_stable,
  output logic [NSUB-1:0]       resp_sub_valid,
  output logic [NSUB*RW-1:0]    resp_sub_dst,
  output logic [NSUB*OFF_W-1:0] resp_sub_off,
  output logic                  evict_valid,
  output logic [PC_W-1:0]       evict_pc,
  output logic                  evict_stable,
  output logic [NSUB-1:0]       evict_sub_valid,
  output logic [NSUB*RW-1:0]    evict_sub_dst,
  output logic [NSUB*OFF_W-1:0] evict_sub_off
);

  logic                  e_v  [NREG];
  logic                  e_st [NREG];
  logic [NSUB-1:0]       e_sv [NREG];
  logic [PC_W-1:0]       e_pc [NREG];
  logic [NSUB*RW-1:0]    e_sd [NREG];
  logic [NSUB*OFF_W-1:0] e_so [NREG];

  wire p_occ = e_v[prod_reg];
  wire p_hit = p_occ && (e_pc[prod_reg] == prod_pc);
  wire p_evict = prod_valid && p_occ && !p_hit;

  logic                  p_st;
  logic [NSUB-1:0]       p_sv;
  logic [NSUB*RW-1:0]    p_sd;
  logic [NSUB*OFF_W-1:0] p_so;

  always_comb begin
    if (fill_valid) begin
      p_st = fill_stable;
      p_sv = fill_sub_valid;
      p_sd = fill_sub_dst;
      p_so = fill_sub_off;
    end else if (p_hit) begin
      p_st = e_st[prod_reg];
      p_sv = e_sv[prod_reg];
      p_sd = e_sd[prod_reg];
      p_so = e_so[prod_reg];
    end else begin
      p_st = 1'b0;
      p_sv = '0;
      p_sd = '0;
      p_so = '0;
    end
  end

  wire fwd = prod_valid && (prod_reg == cons_base);
  wire c_v = fwd || e_v[cons_base];
  wire                  c_st0 = fwd ? p_st : e_st[cons_base];
  wire [NSUB-1:0]       c_sv0 = fwd ? p_sv : e_sv[cons_base];
  wire [NSUB*RW-1:0]    c_sd0 = fwd ? p_sd : e_sd[cons_base];
  wire [NSUB*OFF_W-1:0] c_so0 = fwd ? p_so : e_so[cons_base];

  logic                  c_st;
  logic [NSUB-1:0]       c_sv;
  logic [NSUB*RW-1:0]    c_sd;
  logic [NSUB*OFF_W-1:0] c_so;
  logic                  c_match, c_placed;

  always_comb begin
    c_st = c_st0;
    c_sv = c_sv0;
    c_sd = c_sd0;
    c_so = c_so0;
    c_match = 1'b0;
    c_placed = 1'b0;
    for (int i = 0; i < NSUB; i++)
      if (c_sv0[i] && c_sd0[i*RW +: RW] == cons_dst && c_so0[i*OFF_W +: OFF_W] == cons_off)
        c_match = 1'b1;
    if (c_match) c_st = 1'b1;
    else
      for (int i = 0; i < NSUB; i++)
        if (!c_placed && !c_sv0[i]) begin
          c_sv[i] = 1'b1;
          c_sd[i*RW +: RW] = cons_dst;
          c_so[i*OFF_W +: OFF_W] = cons_off;
          c_placed = 1'b1;
        end
  end

  wire c_wr = cons_valid && c_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) begin
        e_v[r]  <= 1'b0;
        e_st[r] <= 1'b0;
        e_sv[r] <= '0;
      end
      resp_valid      <= 1'b0;
      resp_stable     <= 1'b0;
      resp_sub_valid  <= '0;
      evict_valid     <= 1'b0;
      evict_stable    <= 1'b0;
      evict_sub_valid <= '0;
    end else begin
      if (prod_valid) begin
        e_v[prod_reg]  <= 1'b1;
        e_st[prod_reg] <= p_st;
        e_sv[prod_reg] <= p_sv;
      end
      if (c_wr) begin
        e_st[cons_base] <= c_st;
        e_sv[cons_base] <= c_sv;
      end
      resp_valid      <= prod_valid;
      resp_stable     <= prod_valid && p_st;
      resp_sub_valid  <= prod_valid ? p_sv : '0;
      evict_valid     <= p_evict;
      evict_stable    <= p_evict && e_st[prod_reg];
      evict_sub_valid <= p_evict ? e_sv[prod_reg] : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (prod_valid) begin
      e_pc[prod_reg] <= prod_pc;
      e_sd[prod_reg] <= p_sd;
      e_so[prod_reg] <= p_so;
    end
    if (c_wr) begin
      e_sd[cons_base] <= c_sd;
      e_so[cons_base] <= c_so;
    end
    resp_sub_dst  <= p_sd;
    resp_sub_off  <= p_so;
    evict_pc      <= e_pc[prod_reg];
    evict_sub_dst <= e_sd[prod_reg];
    evict_sub_off <= e_so[prod_reg];
  end

  logic            chk_en;
  logic [RW-1:0]   chk_base;
  logic [NSUB-1:0] chk_sv;
  logic            chk_st;
  always_ff @(posedge clk) begin
    chk_en   <= rst_n && cons_valid && !fwd && e_v[cons_base];
    chk_base <= cons_base;
    chk_sv   <= e_sv[cons_base];
    chk_st   <= e_st[cons_base];
  end

  p_evict_with_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    evict_valid |-> resp_valid);
  p_clean_after_evict_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (evict_valid && !$past(fill_valid)) |-> (!resp_stable && resp_sub_valid == '0));
  p_cons_adds_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    chk_en |-> ($countones(e_sv[chk_base]) <= $countones(chk_sv) + 1));
  p_cons_keeps_subs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    chk_en |-> ((chk_sv & ~e_sv[chk_base]) == '0));
  p_stable_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && chk_st) |-> e_st[chk_base]);

endmodule

// File: tb/tb_addr_producer_table.sv
`timescale 1ns/1ps
module tb_addr_producer_table;
  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic prod_valid = 0, fill_valid = 0, fill_stable = 0, cons_valid = 0;
  logic [4:0] prod_reg = 0, cons_base = 0, cons_dst = 0, cons_off = 0;
  logic [31:0] prod_pc = 0;
  logic [1:0] fill_sub_valid = 0;
  logic [9:0] fill_sub_dst = 0, fill_sub_off = 0;
  logic resp_valid, resp_stable, evict_valid, evict_stable;
  logic [1:0] resp_sub_valid, evict_sub_valid;
  logic [9:0] resp_sub_dst, resp_sub_off, evict_sub_dst, evict_sub_off;
  logic [31:0] evict_pc;

  addr_producer_table dut (.*);

  int checks = 0, fails = 0;
  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  typedef struct packed {
    logic pv; logic [4:0] pr; logic [15:0] pc;
    logic cv; logic [4:0] cb; logic [4:0] cd; logic [4:0] co;
    logic erv; logic est; logic [1:0] esv; logic eev; logic [15:0] epc;
  } row_t;

  localparam row_t VEC [13] = '{
    '{1,3,'h100, 0,0,0,0,  1,0,2'b00, 0,0},      // R1 first producer
    '{0,0,0,     1,3,7,4,  0,0,2'b00, 0,0},      // R4 record load
    '{1,3,'h100, 0,0,0,0,  1,0,2'b01, 0,0},      // R3 R4 hit shows slot0
    '{0,0,0,     1,3,7,4,  0,0,2'b00, 0,0},      // R5 repeat
    '{1,3,'h100, 0,0,0,0,  1,1,2'b01, 0,0},      // R5 stable
    '{0,0,0,     1,3,8,1,  0,0,2'b00, 0,0},      // R4 slot1
    '{0,0,0,     1,3,9,2,  0,0,2'b00, 0,0},      // R6 full
    '{1,3,'h100, 0,0,0,0,  1,1,2'b11, 0,0},      // R6 unchanged
    '{0,0,0,     1,5,1,1,  0,0,2'b00, 0,0},      // R7 empty base
    '{1,5,'h200, 0,0,0,0,  1,0,2'b00, 0,0},      // R7 still empty
    '{1,3,'h300, 0,0,0,0,  1,0,2'b00, 1,'h100},  // R2 evict
    '{1,5,'h204, 1,5,2,3,  1,0,2'b00, 1,'h200},  // R9 R10 same cycle
    '{1,5,'h204, 0,0,0,0,  1,0,2'b01, 0,0}       // R9 load landed
  };

  task automatic idle();
    prod_valid = 0; cons_valid = 0; fill_valid = 0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset resp_valid", resp_valid, 0);
    check("R1 reset evict_valid", evict_valid, 0);
    @(negedge clk) rst_n = 1;

    for (int i = 0; i < 13; i++) begin
      @(negedge clk);
      prod_valid = VEC[i].pv; prod_reg = VEC[i].pr; prod_pc = {16'h0, VEC[i].pc};
      cons_valid = VEC[i].cv; cons_base = VEC[i].cb; cons_dst = VEC[i].cd; cons_off = VEC[i].co;
      fill_valid = 0;
      tick();
      check($sformatf("row%0d R10 resp_valid", i), resp_valid, VEC[i].erv);
      check($sformatf("row%0d R2 evict_valid", i), evict_valid, VEC[i].eev);
      if (VEC[i].erv) begin
        check($sformatf("row%0d R3 resp_stable", i), resp_stable, VEC[i].est);
        check($sformatf("row%0d R4 resp_sub_valid", i), resp_sub_valid, VEC[i].esv);
      end
      if (VEC[i].eev) check($sformatf("row%0d R2 evict_pc", i), evict_pc, {16'h0, VEC[i].epc});
      if (i == 7) begin
        check("R4 slot dst order", resp_sub_dst, {5'd8, 5'd7});
        check("R4 slot off order", resp_sub_off, {5'd1, 5'd4});
      end
      if (i == 10) begin
        check("R2 evict_stable", evict_stable, 1);
        check("R2 evict_sub_valid", evict_sub_valid, 2'b11);
        check("R2 evict_sub_dst", evict_sub_dst, {5'd8, 5'd7});
      end
      if (i == 12) check("R9 slot0 dst", resp_sub_dst[4:0], 2);
    end

    // R8 fill into empty register
    @(negedge clk);
    idle(); prod_valid = 1; prod_reg = 9; prod_pc = 'h400;
    fill_valid = 1; fill_stable = 1; fill_sub_valid = 2'b10;
    fill_sub_dst = {5'd12, 5'd0}; fill_sub_off = {5'd6, 5'd0};
    tick();
    check("R8 fill no evict", evict_valid, 0);
    check("R8 fill stable", resp_stable, 1);
    check("R8 fill subs", resp_sub_valid, 2'b10);
    check("R8 fill dst", resp_sub_dst[9:5], 12);
    check("R8 fill off", resp_sub_off[9:5], 6);
    // R8 fill over occupied with different PC
    @(negedge clk);
    prod_pc = 'h500; fill_stable = 0; fill_sub_valid = 2'b01;
    fill_sub_dst = {5'd0, 5'd4}; fill_sub_off = {5'd0, 5'd3};
    tick();
    check("R8 evict on fill", evict_valid, 1);
    check("R8 evict pc", evict_pc, 'h400);
    check("R8 evict stable", evict_stable, 1);
    check("R8 new subs", resp_sub_valid, 2'b01);
    check("R8 new stable", resp_stable, 0);

    // R1 reset clears table
    @(negedge clk);
    idle(); rst_n = 0;
    tick(); tick();
    @(negedge clk);
    rst_n = 1; prod_valid = 1; prod_reg = 3; prod_pc = 'h300;
    tick();
    check("R1 after reset no evict", evict_valid, 0);
    check("R1 after reset learning", resp_stable, 0);
    check("R1 after reset no subs", resp_sub_valid, 0);
    @(negedge clk) idle();
    tick();
    check("R10 resp drops", resp_valid, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule